// File: doc/BRIEF.md
# Rolling Activate-Window Limiter

This block decides, cycle by cycle, whether a row-activate command may be sent to one rank of a DRAM. It enforces three spacing rules at once: a short minimum distance between any two consecutive activates, a longer distance between two activates that target the same bank group, and a sliding window in which no more than a configured number of activates may fall. All times are given to the block as clock-cycle counts. Conversion from nanoseconds, with rounding up, happens outside the block.

The command scheduler drives a request strobe together with the bank-group index of the candidate activate. It also drives a free-running cycle count that advances by one on every clock. The block answers combinationally with an allow flag. An activate is recorded only in a cycle where it is both requested and allowed. Recording updates the history of recent activate times, the time of the latest activate, and the latest activate time of that bank group.

Top module: `act_window_gate`

## Requirements
- R1: After reset nothing is recorded, so the first activate is allowed whatever its bank group and whatever the programmed values.
- R2: An activate is refused while the cycle count minus the time of the latest recorded activate is below `gap_short`.
- R3: When `gap_long` is nonzero, an activate is refused while the cycle count minus the latest recorded activate time of the same bank group is below `gap_long`. A group with no recorded activate imposes no such limit.
- R4: When `gap_long` is zero, activates to the same bank group are spaced only by `gap_short`.
- R5: Let L be the effective limit. If at least L activates have been recorded, an activate is refused while the cycle count minus the time of the L-th most recent recorded activate is below `win_len`. With fewer than L recorded, the window imposes no limit.
- R6: A `win_len` of zero disables the window check.
- R7: The effective limit L equals `act_limit` when that value is between 1 and MAX_ACTS. An `act_limit` of 0, or one above MAX_ACTS, gives L = MAX_ACTS.
- R8: `act_ok` is a function of the current inputs and the recorded state and does not depend on `act_req`. The state changes only in a cycle where `act_req` and `act_ok` are both high, so a refused request leaves no trace.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cycle_now | input | TW | Free-running cycle count, one step per clock |
| act_req | input | 1 | An activate is requested this cycle |
| act_group | input | GW | Bank group of the requested activate |
| win_len | input | TW | Rolling window length in cycles, 0 disables it |
| act_limit | input | CW | Maximum activates per window (0 or above MAX_ACTS gives MAX_ACTS) |
| gap_short | input | TW | Minimum cycles between any two activates |
| gap_long | input | TW | Minimum cycles between activates to one group, 0 disables it |
| act_ok | output | 1 | The requested activate may issue this cycle |

## Verification
The bench builds the block with its defaults: four bank groups, a four-deep activate history and a 16-bit cycle count. The four-deep history allows a window limit of four and also every smaller limit. The 3-bit limit input can carry both 0 and 7, which reaches both the out-of-range encodings of R7. The runtime inputs are varied across a short/long spacing of 2/4 with a 10-cycle window, a disabled window, a limit of 2 with an 8-cycle window, and an oversized limit. Together these reach every refusal path and its exact release cycle.

// File: rtl/act_window_gate.sv
module act_window_gate #(
  parameter int GROUPS   = 4,
  parameter int MAX_ACTS = 4,
  parameter int TW       = 16,
  localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
  localparam int CW = $clog2(MAX_ACTS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [TW-1:0] cycle_now,
  input  logic          act_req,
  input  logic [GW-1:0] act_group,
  input  logic [TW-1:0] win_len,
  input  logic [CW-1:0] act_limit,
  input  logic [TW-1:0] gap_short,
  input  logic [TW-1:0] gap_long,
  output logic          act_ok
);

  logic [TW-1:0] hist [MAX_ACTS];
  logic [CW-1:0] fill;
  logic [TW-1:0] last_any;
  logic          any_seen;
  logic [TW-1:0] grp_time [GROUPS];
  logic [GROUPS-1:0] grp_seen;

  logic [CW-1:0] eff_lim;
  logic [TW-1:0] oldest;
  logic          win_ok, sp_ok, grp_ok, fire;

  assign eff_lim = (act_limit == '0 || act_limit > CW'(MAX_ACTS)) ? CW'(MAX_ACTS) : act_limit;

  always_comb begin
    oldest = '0;
    for (int i = 0; i < MAX_ACTS; i++)
      if (CW'(i) == eff_lim - CW'(1)) oldest = hist[i];
  end

  assign win_ok = (win_len == '0) || (fill < eff_lim) || ((cycle_now - oldest) >= win_len);
  assign sp_ok  = !any_seen || ((cycle_now - last_any) >= gap_short);
  assign grp_ok = (gap_long == '0) || !grp_seen[act_group] ||
                  ((cycle_now - grp_time[act_group]) >= gap_long);
  assign act_ok = win_ok & sp_ok & grp_ok;
  assign fire   = act_req & act_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < MAX_ACTS; i++) hist[i] <= '0;
      for (int g = 0; g < GROUPS; g++) grp_time[g] <= '0;
      fill     <= '0;
      last_any <= '0;
      any_seen <= 1'b0;
      grp_seen <= '0;
    end else if (fire) begin
      hist[0] <= cycle_now;
      for (int i = 1; i < MAX_ACTS; i++) hist[i] <= hist[i-1];
      if (fill != CW'(MAX_ACTS)) fill <= fill + CW'(1);
      last_any            <= cycle_now;
      any_seen            <= 1'b1;
      grp_time[act_group] <= cycle_now;
      grp_seen[act_group] <= 1'b1;
    end
  end

  p_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fill == '0) |-> act_ok);

  p_short_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req && act_ok) |=> (!act_ok || (cycle_now - $past(cycle_now)) >= gap_short));

  p_long_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_req && act_ok && gap_long != '0) |=>
      (!act_ok || act_group != $past(act_group) || (cycle_now - $past(cycle_now)) >= gap_long));

  p_open_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (win_len == '0 && gap_short == '0 && gap_long == '0) |-> act_ok);

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(act_req && act_ok) |=> ($stable(last_any) && $stable(fill) && $stable(grp_seen)));

endmodule

// File: tb/act_window_gate_tb.sv
module act_window_gate_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cycle_now = '0;
  logic        act_req = 1'b0;
  logic [1:0]  act_group = '0;
  logic [15:0] win_len = '0;
  logic [2:0]  act_limit = '0;
  logic [15:0] gap_short = '0;
  logic [15:0] gap_long = '0;
  logic        act_ok;
  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  act_window_gate u_dut (
    .clk(clk), .rst_n(rst_n), .cycle_now(cycle_now), .act_req(act_req),
    .act_group(act_group), .win_len(win_len), .act_limit(act_limit),
    .gap_short(gap_short), .gap_long(gap_long), .act_ok(act_ok));

  always #10 clk = ~clk;
  always @(posedge clk) cycle_now <= cycle_now + 16'd1;

  // {idle cycles before[7:4], group[3:2], unused[1], expected act_ok[0]}
  // config: win 10, limit 4, short 2, long 4
  localparam logic [7:0] VEC [12] = '{
    8'h01, 8'h04, 8'h05, 8'h04, 8'h04, 8'h09,
    8'h11, 8'h1C, 8'h0D, 8'h19, 8'h14, 8'h05};
  localparam string VTAG [12] = '{
    "R1", "R2", "R2", "R2", "R3", "R3", "R3", "R5", "R5", "R5", "R5", "R5"};

  task automatic chk(input logic got, input logic exp, input string tag);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: act_ok=%0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic req, input logic [1:0] g, input logic exp, input string tag);
    @(negedge clk);
    act_req = req;
    act_group = g;
    #1;
    chk(act_ok, exp, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      act_req = 1'b0;
    end
  endtask

  task automatic do_reset(input logic [15:0] w, input logic [2:0] l,
                          input logic [15:0] s, input logic [15:0] lg);
    @(negedge clk);
    act_req = 1'b0;
    rst_n = 1'b0;
    win_len = w; act_limit = l; gap_short = s; gap_long = lg;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wrap_up();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run did not end");
    wrap_up();
  end

  initial begin
    // R1: reset state, first activate allowed even with tight settings
    do_reset(16'd10, 3'd4, 16'd2, 16'd4);
    step(1'b0, 2'd3, 1'b1, "R1 reset");
    idle(1);

    do_reset(16'd10, 3'd4, 16'd2, 16'd4);
    for (int i = 0; i < 12; i++) begin
      idle(int'(VEC[i][7:4]));
      step(1'b1, VEC[i][3:2], VEC[i][0], VTAG[i]);
    end
    idle(1);

    // R6 and R4: window off, long gap off, same group every cycle
    do_reset(16'd0, 3'd4, 16'd1, 16'd0);
    for (int i = 0; i < 6; i++) step(1'b1, 2'd1, 1'b1, "R6 R4 open");
    idle(1);

    // R5 with limit 2 over 8 cycles; R8 act_ok without request
    do_reset(16'd8, 3'd2, 16'd1, 16'd0);
    step(1'b1, 2'd0, 1'b1, "R5 lim2 t0");
    step(1'b1, 2'd0, 1'b1, "R4 lim2 t1");
    step(1'b0, 2'd0, 1'b0, "R8 no req t2");
    for (int t = 3; t < 8; t++) step(1'b1, 2'd2, 1'b0, "R5 lim2 blocked");
    step(1'b1, 2'd2, 1'b1, "R5 lim2 t8");
    step(1'b1, 2'd3, 1'b1, "R5 lim2 t9");
    idle(1);

    // R7: limit 0 and limit 7 both act as four
    do_reset(16'd20, 3'd0, 16'd1, 16'd0);
    for (int i = 0; i < 4; i++) step(1'b1, 2'(i), 1'b1, "R7 zero limit");
    step(1'b1, 2'd0, 1'b0, "R7 zero limit fifth");
    idle(1);
    do_reset(16'd20, 3'd7, 16'd1, 16'd0);
    for (int i = 0; i < 4; i++) step(1'b1, 2'(i), 1'b1, "R7 big limit");
    step(1'b1, 2'd0, 1'b0, "R7 big limit fifth");
    idle(1);

    wrap_up();
  end
endmodule